// File: doc/BRIEF.md
# Clock tolerance compensation elastic buffer

This block moves a stream of received line symbols from the recovered receive clock into the local core clock. The two clocks run at the same nominal rate but come from separate references, so one side slowly gains on the other. A small dual-clock FIFO absorbs the phase difference. Its write and read pointers cross between domains in Gray code, and its fill level is held near half full.

The fill level is corrected only inside skip ordered sets. Such a set is a comma control symbol followed by one to five skip control symbols. When the buffer runs too full, the write side discards one incoming skip symbol of a set, and it never discards the last one. When the buffer runs too empty, the read side shows one skip symbol twice by holding its pointer for a cycle. Ordinary symbols are never dropped or repeated.

If the buffer hits full or empty anyway, a sticky flag records the fault in the domain where it occurred. The affected side then restarts cleanly at the start of the next ordered set, with the buffer near half full.

Top module: `eb_elastic_buf`

## Requirements
- R1: Every symbol that is not a skip symbol reaches the read side exactly once and in its write order while no fault occurs. A symbol is a control symbol when its control flag is 1. Comma is control with data 0xBC, skip is control with data 0x1C, and a data byte with flag 0 is never treated as either.
- R2: After reset, rd_valid, wr_overflow and rd_underflow are 0. The read side emits nothing until its view of the fill level reaches half the depth (8) with a comma at the head of the buffer.
- R3: When the write-side fill exceeds half plus the hysteresis (above 10), one incoming skip symbol of the current ordered set is discarded. At most one is discarded per set, and only a skip that follows an already-stored skip of the same set. With a read clock 2% slower than the write clock, more skip symbols enter than leave.
- R4: Every ordered set leaving the buffer still carries at least one skip symbol after its comma.
- R5: When the read-side fill is below half minus the hysteresis (under 6) and a skip symbol is at the head, that skip is emitted twice, at most once per ordered set. With a read clock 2% faster, more skip symbols leave than enter.
- R6: A symbol that arrives while the write side sees the buffer full is discarded and wr_overflow sets and stays set. The write side then discards its input until a comma arrives while its fill is at most 8, and stores from that comma on.
- R7: When the read side is emitting and finds the buffer empty, rd_valid goes low and rd_underflow sets and stays set. No stored symbol is lost. Output resumes at a comma once the fill reaches 8.
- R8: With the two clocks equal, the number of skip symbols leaving matches the number entering to within 12 over a run of sets. Neither fault flag asserts during 2% drift in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered receive clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_valid | input | 1 | A symbol is presented this cycle |
| wr_ctl | input | 1 | Control flag of the presented symbol |
| wr_data | input | 8 | Byte of the presented symbol |
| rd_clk | input | 1 | Local core clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_valid | output | 1 | A symbol is emitted this cycle |
| rd_ctl | output | 1 | Control flag of the emitted symbol |
| rd_data | output | 8 | Byte of the emitted symbol |
| wr_overflow | output | 1 | Sticky full fault, write domain |
| rd_underflow | output | 1 | Sticky empty fault, read domain |

## Verification
The bench builds the block with its defaults: 16 entries, a hysteresis of 2 and two synchronizer stages. At these values a read clock 2% off nominal crosses a threshold within a few ordered sets. The drift is large enough to demand a drop or an insert roughly every other set, yet small enough that the one-per-set correction keeps up. Stopping the read clock fills the 16 entries within a few dozen writes, and idling the writer empties them, so both fault paths and their restart at a comma are exercised in a short run.

// File: rtl/eb_pkg.sv
`timescale 1ns/1ps
package eb_pkg;

    localparam logic [7:0] K_COMMA = 8'hBC;
    localparam logic [7:0] K_SKIP  = 8'h1C;

    typedef struct packed {
        logic       ctl;
        logic [7:0] data;
    } sym_t;

    typedef enum logic {WR_NORM, WR_HUNT} wr_state_e;
    typedef enum logic {RD_WAIT, RD_RUN}  rd_state_e;

    function automatic logic is_comma(sym_t s);
        return s.ctl && (s.data == K_COMMA);
    endfunction

    function automatic logic is_skip(sym_t s);
        return s.ctl && (s.data == K_SKIP);
    endfunction

endpackage

// File: rtl/eb_gray_sync.sv
`timescale 1ns/1ps
module eb_gray_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= gray_in;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    // Gray to binary: each bit is the parity of itself and all higher bits
    for (genvar b = 0; b < W; b++) begin : g_bin
        assign bin_out[b] = ^(stage_q[STAGES-1] >> b);
    end

endmodule

// File: rtl/eb_store.sv
`timescale 1ns/1ps
module eb_store
    import eb_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  sym_t          wdata,
    input  logic [AW-1:0] raddr,
    output sym_t          rdata
);
    localparam int DEPTH = 1 << AW;

    sym_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/eb_wr_ctrl.sv
`timescale 1ns/1ps
module eb_wr_ctrl
    import eb_pkg::*;
#(
    parameter int AW   = 4,
    parameter int HYST = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  sym_t          in_sym,
    input  logic [AW:0]   rptr_bin,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [AW:0]   wptr_gray,
    output logic          ovf
);
    localparam int DEPTH = 1 << AW;
    localparam logic [AW:0] FILL_FULL = (AW+1)'(DEPTH);
    localparam logic [AW:0] FILL_HALF = (AW+1)'(DEPTH / 2);
    localparam logic [AW:0] FILL_HIGH = (AW+1)'(DEPTH / 2 + HYST);

    wr_state_e   state;
    logic [AW:0] wptr, wptr_nxt, fill_w;
    logic        in_set, skip_kept, adj_done;
    logic        skip_drop, ovf_now;

    assign fill_w   = wptr - rptr_bin;
    assign wptr_nxt = wptr + 1'b1;
    assign wr_addr  = wptr[AW-1:0];

    always_comb begin
        wr_en     = 1'b0;
        skip_drop = 1'b0;
        ovf_now   = 1'b0;
        if (in_valid) begin
            if (state == WR_HUNT) begin
                wr_en = is_comma(in_sym) && (fill_w <= FILL_HALF);
            end else if (is_skip(in_sym) && in_set && skip_kept &&
                         !adj_done && (fill_w > FILL_HIGH)) begin
                skip_drop = 1'b1;
            end else if (fill_w >= FILL_FULL) begin
                ovf_now = 1'b1;
            end else begin
                wr_en = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= WR_NORM;
            wptr      <= '0;
            wptr_gray <= '0;
            in_set    <= 1'b0;
            skip_kept <= 1'b0;
            adj_done  <= 1'b0;
            ovf       <= 1'b0;
        end else begin
            if (wr_en) begin
                wptr      <= wptr_nxt;
                wptr_gray <= wptr_nxt ^ (wptr_nxt >> 1);
            end
            if (ovf_now) begin
                ovf   <= 1'b1;
                state <= WR_HUNT;
            end else if (wr_en && state == WR_HUNT) begin
                state <= WR_NORM;
            end
            if (wr_en || skip_drop) begin
                if (is_comma(in_sym)) begin
                    in_set    <= 1'b1;
                    skip_kept <= 1'b0;
                    adj_done  <= 1'b0;
                end else if (is_skip(in_sym)) begin
                    if (wr_en)     skip_kept <= 1'b1;
                    if (skip_drop) adj_done  <= 1'b1;
                end else begin
                    in_set <= 1'b0;
                end
            end
        end
    end

    // R1
    ordinary_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !is_skip(in_sym) && state == WR_NORM && fill_w < FILL_FULL)
        |=> (wptr == $past(wptr) + 1'b1));

    // R6
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fill_w <= FILL_FULL);

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

endmodule

// File: rtl/eb_rd_ctrl.sv
`timescale 1ns/1ps
module eb_rd_ctrl
    import eb_pkg::*;
#(
    parameter int AW   = 4,
    parameter int HYST = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW:0]   wptr_bin,
    input  sym_t          head,
    output logic [AW-1:0] rd_addr,
    output logic [AW:0]   rptr_gray,
    output logic          out_valid,
    output sym_t          out_sym,
    output logic          udf
);
    localparam int DEPTH = 1 << AW;
    localparam logic [AW:0] FILL_HALF = (AW+1)'(DEPTH / 2);
    localparam logic [AW:0] FILL_LOW  = (AW+1)'(DEPTH / 2 - HYST);

    rd_state_e   state;
    logic [AW:0] rptr, rptr_nxt, fill_r;
    logic        ins_done;
    logic        pop, emit, repeat_skip, go_run, go_wait;

    assign fill_r   = wptr_bin - rptr;
    assign rptr_nxt = rptr + 1'b1;
    assign rd_addr  = rptr[AW-1:0];

    always_comb begin
        pop         = 1'b0;
        emit        = 1'b0;
        repeat_skip = 1'b0;
        go_run      = 1'b0;
        go_wait     = 1'b0;
        if (state == RD_WAIT) begin
            if (fill_r >= FILL_HALF) begin
                pop = 1'b1;
                if (is_comma(head)) begin
                    emit   = 1'b1;
                    go_run = 1'b1;
                end
            end
        end else begin
            if (fill_r == '0) begin
                go_wait = 1'b1;
            end else begin
                emit = 1'b1;
                if (is_skip(head) && !ins_done && (fill_r < FILL_LOW))
                    repeat_skip = 1'b1;
                else
                    pop = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= RD_WAIT;
            rptr      <= '0;
            rptr_gray <= '0;
            ins_done  <= 1'b0;
            out_valid <= 1'b0;
            out_sym   <= '0;
            udf       <= 1'b0;
        end else begin
            out_valid <= emit;
            if (emit) out_sym <= head;
            if (pop) begin
                rptr      <= rptr_nxt;
                rptr_gray <= rptr_nxt ^ (rptr_nxt >> 1);
            end
            if (go_run)  state <= RD_RUN;
            if (go_wait) begin
                state <= RD_WAIT;
                udf   <= 1'b1;
            end
            if (emit && is_comma(head)) ins_done <= 1'b0;
            else if (repeat_skip)       ins_done <= 1'b1;
        end
    end

    // R1
    no_repeat_chk: assert property (@(posedge clk) disable iff (rst)
        (state == RD_RUN && fill_r != '0 && !is_skip(head))
        |=> (out_valid && rptr == $past(rptr) + 1'b1));

    // R7
    empty_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_r == '0) |=> !out_valid);

    // R7
    udf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        udf |=> udf);

endmodule

// File: rtl/eb_elastic_buf.sv
`timescale 1ns/1ps
module eb_elastic_buf
    import eb_pkg::*;
#(
    parameter int AW          = 4,
    parameter int HYST        = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       wr_clk,
    input  logic       wr_rst,
    input  logic       wr_valid,
    input  logic       wr_ctl,
    input  logic [7:0] wr_data,
    input  logic       rd_clk,
    input  logic       rd_rst,
    output logic       rd_valid,
    output logic       rd_ctl,
    output logic [7:0] rd_data,
    output logic       wr_overflow,
    output logic       rd_underflow
);
    localparam int PW = AW + 1;

    sym_t          in_sym, head, out_sym;
    logic          wr_en;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [PW-1:0] wptr_gray, rptr_gray, wptr_in_rd, rptr_in_wr;

    assign in_sym = '{ctl: wr_ctl, data: wr_data};

    eb_wr_ctrl #(.AW(AW), .HYST(HYST)) u_wr (
        .clk       (wr_clk),
        .rst       (wr_rst),
        .in_valid  (wr_valid),
        .in_sym    (in_sym),
        .rptr_bin  (rptr_in_wr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wptr_gray (wptr_gray),
        .ovf       (wr_overflow)
    );

    eb_store #(.AW(AW)) u_mem (
        .clk   (wr_clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (in_sym),
        .raddr (rd_addr),
        .rdata (head)
    );

    eb_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
        .clk     (rd_clk),
        .rst     (rd_rst),
        .gray_in (wptr_gray),
        .bin_out (wptr_in_rd)
    );

    eb_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
        .clk     (wr_clk),
        .rst     (wr_rst),
        .gray_in (rptr_gray),
        .bin_out (rptr_in_wr)
    );

    eb_rd_ctrl #(.AW(AW), .HYST(HYST)) u_rd (
        .clk       (rd_clk),
        .rst       (rd_rst),
        .wptr_bin  (wptr_in_rd),
        .head      (head),
        .rd_addr   (rd_addr),
        .rptr_gray (rptr_gray),
        .out_valid (rd_valid),
        .out_sym   (out_sym),
        .udf       (rd_underflow)
    );

    assign rd_ctl  = out_sym.ctl;
    assign rd_data = out_sym.data;

endmodule

// File: tb/sim_eb_elastic_buf.sv
`timescale 1ns/1ps
module sim_eb_elastic_buf;
    import eb_pkg::*;

    logic wr_clk = 1'b0, rd_clk = 1'b0;
    logic wr_rst, rd_rst, wr_valid, wr_ctl, rd_valid, rd_ctl;
    logic wr_overflow, rd_underflow;
    logic [7:0] wr_data, rd_data;
    realtime rhalf = 5.0;
    bit rclk_run = 1'b1;

    always #5 wr_clk = ~wr_clk;
    always begin
        #(rhalf);
        if (rclk_run) rd_clk = ~rd_clk;
    end

    eb_elastic_buf u0 (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_valid(wr_valid), .wr_ctl(wr_ctl),
        .wr_data(wr_data), .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_valid(rd_valid),
        .rd_ctl(rd_ctl), .rd_data(rd_data), .wr_overflow(wr_overflow),
        .rd_underflow(rd_underflow)
    );

    int n_chk = 0, n_bad = 0;
    logic [8:0] exp_q [0:16383];
    int wi = 0, ri = 0, resync_idx = 0;
    int skp_in = 0, skp_out = 0, n_out = 0;
    bit hunt = 1'b0, in_set_o = 1'b0;
    int set_cnt = 0, cyc = 0;
    logic [7:0] dval = 8'h00;

    // {reps, data length, skips per set, read speed (0 equal,1 slow,2 fast), expected balance}
    localparam int NSEG = 6;
    localparam logic [27:0] SEG [NSEG] = '{
        {8'd20,  8'd12, 4'd2, 4'd0, 4'd0},
        {8'd125, 8'd20, 4'd3, 4'd1, 4'd1},
        {8'd60,  8'd16, 4'd1, 4'd0, 4'd0},
        {8'd125, 8'd20, 4'd3, 4'd2, 4'd2},
        {8'd40,  8'd10, 4'd5, 4'd0, 4'd0},
        {8'd80,  8'd30, 4'd2, 4'd1, 4'd1}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send(input bit c, input logic [7:0] d, input bit track);
        @(negedge wr_clk);
        wr_valid = 1'b1; wr_ctl = c; wr_data = d;
        if (c && d == K_SKIP) skp_in++;
        else if (track) begin exp_q[wi] = {c, d}; wi++; end
    endtask

    task automatic idle(input int n);
        @(negedge wr_clk);
        wr_valid = 1'b0;
        repeat (n - 1) @(negedge wr_clk);
    endtask

    task automatic send_set(input int nskp, input int dlen);
        send(1'b1, K_COMMA, 1'b1);
        for (int k = 0; k < nskp; k++) send(1'b1, K_SKIP, 1'b1);
        for (int k = 0; k < dlen; k++) begin send(1'b0, dval, 1'b1); dval++; end
    endtask

    // read-side monitor
    always @(negedge rd_clk) begin
        if (!rd_rst && rd_valid) begin
            n_out++;
            if (rd_ctl && rd_data == K_SKIP) begin
                skp_out++;
                if (in_set_o) set_cnt++;
            end else begin
                if (hunt) begin
                    in_set_o = 1'b0;
                    if (rd_ctl && rd_data == K_COMMA) begin hunt = 1'b0; ri = resync_idx; end
                end else if (in_set_o) begin
                    chk(set_cnt >= 1, "R4 skips left in set", set_cnt, 1);
                    in_set_o = 1'b0;
                end
                if (!hunt) begin
                    chk(ri < wi && {rd_ctl, rd_data} == exp_q[ri], "R1 order",
                        int'({rd_ctl, rd_data}), (ri < wi) ? int'(exp_q[ri]) : -1);
                    ri++;
                    if (rd_ctl && rd_data == K_COMMA) begin in_set_o = 1'b1; set_cnt = 0; end
                end
            end
        end
    end

    always @(posedge wr_clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        wr_rst = 1'b1; rd_rst = 1'b1; wr_valid = 1'b0; wr_ctl = 1'b0; wr_data = 8'h00;
        repeat (6) @(negedge wr_clk);
        wr_rst = 1'b0; rd_rst = 1'b0;
        @(negedge wr_clk);
        chk(rd_valid == 1'b0, "R2 reset valid", rd_valid, 0);
        chk(wr_overflow == 1'b0, "R2 reset overflow", wr_overflow, 0);
        chk(rd_underflow == 1'b0, "R2 reset underflow", rd_underflow, 0);

        // below half: nothing may leave
        send_set(2, 3);
        idle(20);
        chk(n_out == 0, "R2 waits for half fill", n_out, 0);
        chk(rd_underflow == 1'b0, "R2 no underflow while waiting", rd_underflow, 0);

        for (int s = 0; s < NSEG; s++) begin
            logic [27:0] row;
            int i0, o0, bal;
            row = SEG[s];
            rhalf = (row[7:4] == 4'd1) ? 5.1 : (row[7:4] == 4'd2) ? 4.9 : 5.0;
            i0 = skp_in; o0 = skp_out;
            for (int r = 0; r < int'(row[27:20]); r++) send_set(int'(row[11:8]), int'(row[19:12]));
            bal = (skp_out - o0) - (skp_in - i0);
            case (row[3:0])
                4'd1:    chk(bal <= -20, "R3 net skip removal", bal, -20);
                4'd2:    chk(bal >= 20, "R5 net skip insertion", bal, 20);
                default: chk(bal >= -12 && bal <= 12, "R8 balanced skips", bal, 0);
            endcase
        end
        rhalf = 5.0;
        chk(wr_overflow == 1'b0, "R8 no overflow under drift", wr_overflow, 0);
        chk(rd_underflow == 1'b0, "R8 no underflow under drift", rd_underflow, 0);

        // underflow: writer goes quiet
        idle(40);
        chk(rd_underflow == 1'b1, "R7 underflow flag", rd_underflow, 1);
        chk(rd_valid == 1'b0, "R7 valid low when empty", rd_valid, 0);
        chk(ri == wi, "R7 nothing lost before underflow", ri, wi);
        chk(wr_overflow == 1'b0, "R6 no overflow on drain", wr_overflow, 0);
        send_set(2, 20);
        idle(40);
        chk(ri == wi, "R7 resumes at comma", ri, wi);
        chk(rd_underflow == 1'b1, "R7 underflow sticky", rd_underflow, 1);

        // overflow: read clock halted
        send(1'b1, K_COMMA, 1'b1); send(1'b1, K_SKIP, 1'b1);
        for (int k = 0; k < 30; k++) send(1'b0, 8'h55, 1'b1);
        hunt = 1'b1;
        rclk_run = 1'b0;
        for (int k = 0; k < 30; k++) send(1'b0, 8'h55, 1'b0);
        chk(wr_overflow == 1'b1, "R6 overflow flag", wr_overflow, 1);
        rclk_run = 1'b1;
        for (int k = 0; k < 40; k++) send(1'b0, 8'h66, 1'b0);
        resync_idx = wi;
        send_set(2, 20);
        idle(60);
        chk(hunt == 1'b0 && ri == wi, "R6 restart at next ordered set", ri, wi);
        chk(wr_overflow == 1'b1, "R6 overflow sticky", wr_overflow, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule